// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a down-counter that produces a regular interrupt for an operating-system tick. Software sees four 32-bit registers on a word-addressed bus with separate read and write strobes: control/status at word 0, reload at word 1, current count at word 2 and calibration at word 3. Once enabled, the counter drops by one on each selected tick. The tick is either every core clock or each cycle in which an already-qualified external reference pulse is high. When the count steps from 1 to 0 the block sets a sticky wrap flag and, if interrupts are enabled, pulses an interrupt request. On the next tick the reload value is copied back in.

Read data is combinational and is valid in the same cycle as the read strobe. It is zero in any cycle without a read strobe. The counter logic is a two-state machine. `ST_ZERO` means the count is at zero and the next tick loads the reload value. `ST_DOWN` means the count is non-zero and the next tick decrements it. The transitions are:
- LOAD: `ST_ZERO` to `ST_DOWN` on a tick with a non-zero reload value.
- PARK: `ST_ZERO` to `ST_ZERO` on a tick with a zero reload value.
- STEP: `ST_DOWN` to `ST_DOWN` on a tick with a count above 1.
- CROSS: `ST_DOWN` to `ST_ZERO` on a tick with a count of 1. This is the zero-crossing.
- CLEAR: from either state to `ST_ZERO` on any write to the current-value register. CLEAR takes priority over a tick in the same cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset the control bits, the wrap flag, the interrupt request, the reload value and the count are all 0.
- R2: Control bit 0 is the enable. While it is 0 the count holds its value.
- R3: Control bit 2 selects the tick. A value of 1 counts every clock. A value of 0 counts only in cycles where `ref_tick` is 1.
- R4: Each tick decrements the count. A tick at count 0 loads the reload value instead. The live count reads in bits 23:0 of word 2.
- R5: Word 1 stores a 24-bit reload value in bits 23:0. Bits 31:24 read as 0.
- R6: Control bit 16 is the wrap flag. It becomes 1 on a 1-to-0 step. A control read returns the flag's current value and clears it afterwards, unless a crossing happens in the same cycle, in which case the flag stays 1.
- R7: A write of any data to word 2 sets the count to 0 and clears the flag. It takes priority over a tick in the same cycle.
- R8: `irq` is high for exactly the one cycle after each crossing, and only when control bit 1 was set at that crossing.
- R9: With a reload value of 0 the count stays at 0 and the flag is never set again.
- R10: Word 3 is read-only. Bits 23:0 hold the parameter for a 10 ms reload value, bit 30 the inexact mark and bit 31 the no-reference mark.
- R11: Control bits other than 0, 1, 2 and 16 read as 0, and writes to them and to bit 16 have no effect.
- R12: `bus_rdata` is 0 in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Qualified external reference tick, one clock wide per tick |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request pulse |

## Verification
Read data belongs to the strobe cycle itself. The count, the flag and the control bits change at the clock edge that ends a strobe or tick cycle, so a read shows their new values from the following cycle onward. The interrupt pulse is seen in the cycle after the edge that performed the crossing. The bench drives inputs on the falling edge, samples 1 ns later, and compares against a behavioural model updated on every rising edge. Directed sequences line up a control read exactly with the crossing edge to exercise the same-cycle case.

// File: rtl/tick_pkg.sv
package tick_pkg;
    localparam int unsigned WORD_W = 32;

    // Bit positions of the control/status word
    localparam int unsigned CTL_EN_BIT   = 0;
    localparam int unsigned CTL_IE_BIT   = 1;
    localparam int unsigned CTL_SRC_BIT  = 2;
    localparam int unsigned CTL_WRAP_BIT = 16;

    // Bit positions of the calibration word
    localparam int unsigned CAL_SKEW_BIT  = 30;
    localparam int unsigned CAL_NOREF_BIT = 31;

    typedef enum logic [1:0] {
        A_CTRL    = 2'd0,
        A_RELOAD  = 2'd1,
        A_CURRENT = 2'd2,
        A_CALIB   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic src;
        logic ie;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/tick_source.sv
module tick_source (
    input  logic en,
    input  logic src_core,
    input  logic ref_tick,
    output logic tick
);
    always_comb begin
        tick = en & (src_core | ref_tick);
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_clear,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             zero_cross
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    typedef enum logic {ST_ZERO, ST_DOWN} cnt_state_e;

    cnt_state_e       state, state_n;
    logic [CNT_W-1:0] count_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ZERO;
            count <= ZERO;
        end else begin
            state <= state_n;
            count <= count_n;
        end
    end

    always_comb begin
        state_n    = state;
        count_n    = count;
        zero_cross = 1'b0;
        unique case (state)
            ST_ZERO: begin
                if (tick) begin
                    count_n = reload;
                    state_n = (reload == ZERO) ? ST_ZERO : ST_DOWN;
                end
            end
            ST_DOWN: begin
                if (tick) begin
                    count_n = count - ONE;
                    if (count == ONE) begin
                        state_n    = ST_ZERO;
                        zero_cross = 1'b1;
                    end
                end
            end
        endcase
        if (cnt_clear) begin
            count_n    = ZERO;
            state_n    = ST_ZERO;
            zero_cross = 1'b0;
        end
    end

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (count == ZERO));
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_clear) |=> $stable(count));
    a_r4_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_clear && count == ZERO) |=> (count == $past(reload)));
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int unsigned      CNT_W     = 24,
    parameter logic [CNT_W-1:0] CAL_TENMS = '0,
    parameter logic             CAL_SKEW  = 1'b0,
    parameter logic             CAL_NOREF = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              zero_cross,
    output logic [WORD_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              cnt_clear,
    output logic              irq
);
    reg_addr_e addr;
    logic      wrap_flag;
    logic      rd_ctrl, wr_ctrl, wr_reload;
    logic      wdata_unused;

    always_comb begin
        addr      = reg_addr_e'(bus_addr);
        rd_ctrl   = bus_rd && (addr == A_CTRL);
        wr_ctrl   = bus_wr && (addr == A_CTRL);
        wr_reload = bus_wr && (addr == A_RELOAD);
        cnt_clear = bus_wr && (addr == A_CURRENT);
    end

    assign wdata_unused = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            reload    <= '0;
            wrap_flag <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en  <= bus_wdata[CTL_EN_BIT];
                ctrl.ie  <= bus_wdata[CTL_IE_BIT];
                ctrl.src <= bus_wdata[CTL_SRC_BIT];
            end
            if (wr_reload) begin
                reload <= bus_wdata[CNT_W-1:0];
            end
            if (zero_cross) begin
                wrap_flag <= 1'b1;
            end else if (rd_ctrl || cnt_clear) begin
                wrap_flag <= 1'b0;
            end
            irq <= zero_cross & ctrl.ie;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (addr)
                A_CTRL: begin
                    bus_rdata[CTL_EN_BIT]   = ctrl.en;
                    bus_rdata[CTL_IE_BIT]   = ctrl.ie;
                    bus_rdata[CTL_SRC_BIT]  = ctrl.src;
                    bus_rdata[CTL_WRAP_BIT] = wrap_flag;
                end
                A_RELOAD:  bus_rdata[CNT_W-1:0] = reload;
                A_CURRENT: bus_rdata[CNT_W-1:0] = count;
                A_CALIB: begin
                    bus_rdata[CNT_W-1:0]    = CAL_TENMS;
                    bus_rdata[CAL_SKEW_BIT]  = CAL_SKEW;
                    bus_rdata[CAL_NOREF_BIT] = CAL_NOREF;
                end
            endcase
        end
    end

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !zero_cross) |=> !wrap_flag);
    a_r6_cross_sets: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cross |=> wrap_flag);
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ctrl.ie) && wrap_flag));
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int unsigned      CNT_W     = 24,
    parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(2499),
    parameter logic             CAL_SKEW  = 1'b1,
    parameter logic             CAL_NOREF = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             cnt_clear;
    logic             zero_cross;

    tick_source u_src (
        .en       (ctrl.en),
        .src_core (ctrl.src),
        .ref_tick (ref_tick),
        .tick     (tick)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cnt_clear  (cnt_clear),
        .reload     (reload),
        .count      (count),
        .zero_cross (zero_cross)
    );

    tick_regs #(
        .CNT_W     (CNT_W),
        .CAL_TENMS (CAL_TENMS),
        .CAL_SKEW  (CAL_SKEW),
        .CAL_NOREF (CAL_NOREF)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count      (count),
        .zero_cross (zero_cross),
        .bus_rdata  (bus_rdata),
        .ctrl       (ctrl),
        .reload     (reload),
        .cnt_clear  (cnt_clear),
        .irq        (irq)
    );
endmodule

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
    localparam logic [23:0] T_TENMS = 24'd1234;
    localparam logic        T_SKEW  = 1'b1;
    localparam logic        T_NOREF = 1'b1;

    logic        clk = 0, rst_n = 0, ref_tick = 0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    // behavioural model state
    bit m_en, m_ie, m_src, m_flag, m_irq;
    int m_cnt, m_rld;

    always #2 clk = ~clk;

    tick_timer #(.CNT_W(24), .CAL_TENMS(T_TENMS), .CAL_SKEW(T_SKEW), .CAL_NOREF(T_NOREF)) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0; m_cnt = 0; m_rld = 0;
        end else begin
            bit tk, zc, clr, rdc;
            int nc;
            clr = bus_wr && bus_addr == 2;
            rdc = bus_rd && bus_addr == 0;
            tk  = m_en && (m_src || ref_tick);
            zc  = tk && m_cnt == 1 && !clr;
            nc  = clr ? 0 : (tk ? (m_cnt == 0 ? m_rld : m_cnt - 1) : m_cnt);
            if (zc) m_flag = 1; else if (clr || rdc) m_flag = 0;
            m_irq = zc && m_ie;
            if (bus_wr && bus_addr == 0) begin
                m_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2];
            end
            if (bus_wr && bus_addr == 1) m_rld = int'(bus_wdata[23:0]);
            m_cnt = nc;
        end
    end

    function automatic logic [31:0] model_rdata();
        logic [31:0] v = 0;
        if (bus_rd) begin
            case (bus_addr)
                2'd0: begin v[0] = m_en; v[1] = m_ie; v[2] = m_src; v[16] = m_flag; end
                2'd1: v[23:0] = m_rld[23:0];
                2'd2: v[23:0] = m_cnt[23:0];
                default: begin v[23:0] = T_TENMS; v[30] = T_SKEW; v[31] = T_NOREF; end
            endcase
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // one bus cycle; result is read data of that cycle
    task automatic cyc(input bit r, input bit w, input logic [1:0] a,
                       input logic [31:0] d, output logic [31:0] q);
        string tg;
        @(negedge clk);
        bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        q = bus_rdata;
        chk("R8 irq", {31'b0, irq}, {31'b0, m_irq});
        if (!r) tg = "R12 idle rdata";
        else case (a)
            2'd0: tg = "R6 ctrl read";
            2'd1: tg = "R5 reload read";
            2'd2: tg = "R4 count read";
            default: tg = "R10 calib read";
        endcase
        chk(tg, q, model_rdata());
    endtask

    task automatic idle(input int n);
        logic [31:0] q;
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, q);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] q);
        cyc(1, 0, a, 0, q);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        logic [31:0] q;
        cyc(0, 1, a, d, q);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] q, q2;
        bit seen;
        #9 rst_n = 1;
        // R1 reset state
        rd(0, q); chk("R1 ctrl", q, 0);
        rd(1, q); chk("R1 reload", q, 0);
        rd(2, q); chk("R1 count", q, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        rd(3, q); chk("R10 calib", q, {T_NOREF, T_SKEW, 6'b0, T_TENMS});
        // R10 write ignored
        wr(3, 32'h0);
        rd(3, q); chk("R10 calib after write", q, {T_NOREF, T_SKEW, 6'b0, T_TENMS});
        // R5 upper bits
        wr(1, 32'hFFFF_FFFF);
        rd(1, q); chk("R5 reload width", q, 32'h00FF_FFFF);
        // R11 reserved bits ignored
        wr(0, 32'hFFFF_FFF8);
        rd(0, q); chk("R11 reserved", q, 0);
        wr(1, 3);
        // run on core clock with interrupts
        wr(0, 32'h7);
        for (int i = 0; i < 12; i++) rd(2, q);
        // R11 bit16 write ignored, R6 flag clears on read
        wr(0, 32'h0001_0007);
        rd(0, q);
        rd(0, q);
        // R6 same-cycle read and crossing: CVR write then reload 3 -> 3,2,1,0
        wr(2, 32'hDEAD_BEEF);
        idle(3);
        rd(0, q);  chk("R6 read at crossing old flag", q, 32'h7);
        rd(0, q);  chk("R6 flag kept", q, 32'h0001_0007);
        chk("R8 pulse after crossing", {31'b0, irq}, 1);
        rd(0, q);  chk("R6 flag cleared", q, 32'h7);
        chk("R8 single pulse", {31'b0, irq}, 0);
        // R7 clear while running
        idle(2);
        wr(2, 0);
        rd(2, q);  chk("R7 count cleared", q, 0);
        rd(0, q);  chk("R7 flag cleared", q[16], 0);
        // R2 disable holds
        wr(0, 32'h6);
        rd(2, q); idle(5); rd(2, q2);
        chk("R2 hold", q2, q);
        // R3 reference source, no ref ticks
        wr(0, 32'h3);
        rd(2, q); idle(6); rd(2, q2);
        chk("R3 no ref tick", q2, q);
        for (int i = 0; i < 24; i++) begin
            ref_tick = (i % 3 == 0);
            rd(2 - 2 * (i % 2), q);
        end
        ref_tick = 0;
        // R8 gating: no irq with ie=0
        wr(0, 32'h5);
        seen = 0;
        for (int i = 0; i < 16; i++) begin rd(2, q); if (irq) seen = 1; end
        chk("R8 irq masked", {31'b0, seen}, 0);
        // R9 reload zero
        wr(1, 0);
        wr(2, 0);
        rd(0, q);
        wr(0, 32'h7);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            rd(2, q); chk("R9 count stays zero", q, 0);
            if (irq) seen = 1;
        end
        rd(0, q); chk("R9 no flag", q[16], 0);
        chk("R9 no irq", {31'b0, seen}, 0);
        idle(4);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule